// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a multi-channel event timer. Several such channels share one free-running tick counter that lives outside the block. Each channel holds its own comparator and a hidden period register. It emits a one-clock fire pulse when the shared counter reaches the programmed comparator value. Software programs the channel through a small configuration word and through two strobes that write the lower and upper halves of the comparator. It reads back the comparator and the configuration.

The channel has two operating styles. In one-shot mode it fires once per arming. In periodic mode the comparator advances by the period after each match, one step per clock, until the match point lies ahead of the counter again. A self-clearing set-value bit decides whether a comparator write in periodic mode also loads the visible comparator, or only the hidden period. A narrow mode uses only the lower half of the counter and the comparator. In narrow one-shot mode the channel also fires when that lower half wraps around, and then fires again at the real match. Interrupt routing, status bits and address decoding belong to the surrounding timer.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset `cmp_o` is all ones, the period is zero, `cfg_o[3:0]` is 0, `cfg_o[5:4]` reads 2'b11 (periodic-capable at bit 4, wide-capable at bit 5), and `fire_o` is low.
- R2: The configuration word has enable at bit 0, periodic at bit 1, narrow at bit 2 and set-value at bit 3. Enable going 0→1 while `glb_en_i` is 1 arms the channel. `fire_o` is high for exactly one clock, on the clock after the first cycle in which `signed(cmp − count) <= 0` at full width.
- R3: A comparator that already lies in the past when the channel arms counts as reached, so the channel fires on the next clock.
- R4: No pulse is produced while enable is 0 or `glb_en_i` is 0. Enable going 1→0 disarms the channel. A 0→1 edge of `glb_en_i` with enable already set arms it.
- R5: In one-shot mode the channel fires once per arming and stays silent afterwards, even if the counter keeps running past the comparator.
- R6: In periodic mode a write to either comparator half updates the matching period half. It updates the comparator half only if set-value is 1. In one-shot mode the write always updates the comparator half.
- R7: Set-value clears itself after a write to either comparator half.
- R8: In periodic mode with a nonzero period, a match fires once and adds the period to the comparator. The channel keeps adding one period per clock, without firing, until the comparator lies ahead of the counter.
- R9: Writing a configuration with narrow set clears the upper halves of the comparator and the period in the same clock. In narrow mode only the lower halves are compared and accumulated.
- R10: In narrow periodic mode a period written to either half is clamped to at most 0x7FFF_FFFF.
- R11: In narrow one-shot mode, if the match lies beyond the next wrap of the lower counter half, the channel fires once when that half wraps and once more at the match.
- R12: A period of 0 in periodic mode behaves as one-shot. The comparator does not move after the match.
- R13: A comparator write while the channel is enabled under `glb_en_i` re-arms it against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Shared free-running tick counter |
| glb_en_i | input | 1 | Global enable of the timer |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration bits: set-value, narrow, periodic, enable (bit 3 down to 0) |
| cmp_lo_we_i | input | 1 | Write strobe for the lower comparator half |
| cmp_hi_we_i | input | 1 | Write strobe for the upper comparator half |
| cmp_wdata_i | input | CNT_W/2 | Comparator write data |
| cmp_o | output | CNT_W | Comparator read-back |
| cfg_o | output | 6 | Configuration read-back including capability bits |
| fire_o | output | 1 | One-clock match pulse |

## Verification
The bench builds the channel with the default CNT_W of 64, so the narrow half is 32 bits wide. This puts the 0x7FFF_FFFF period clamp and the 0xFFFF_FFFF lower-half wrap in reach. Because the bench drives the counter directly, it can jump it across the upper half and across long intervals. This reaches narrow-only matching, periodic catch-up over several missed periods, and past-comparator arming within a few clocks.

// File: rtl/evt_pkg.sv
// Package: shared configuration type and field positions for the comparator channel.
// Assumes the software-writable part of the configuration is exactly four bits.
package evt_pkg;
    localparam int CFG_W     = 6;
    localparam int CFG_WR_W  = 4;
    localparam int CFG_EN    = 0;
    localparam int CFG_PER   = 1;
    localparam int CFG_NAR   = 2;
    localparam int CFG_SETV  = 3;

    typedef struct packed {
        logic setv;
        logic narrow;
        logic periodic;
        logic en;
    } chan_cfg_t;
endpackage

// File: rtl/evt_reach.sv
// Module: decides whether the comparator is reached by the counter.
// "Reached" means the signed difference cmp - count is zero or negative,
// taken over the full width or over the lower half in narrow mode.
module evt_reach #(
    parameter int W = 64
) (
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] count_i,
    input  logic         narrow_i,
    output logic         reached_o
);
    localparam int HW = W / 2;

    logic [W-1:0]  diff_w;
    logic [HW-1:0] diff_n;

    // Difference at both widths, sign and zero test chosen by mode.
    always_comb begin
        diff_w = cmp_i - count_i;
        diff_n = cmp_i[HW-1:0] - count_i[HW-1:0];
        if (narrow_i) reached_o = diff_n[HW-1] || (diff_n == '0);
        else          reached_o = diff_w[W-1]  || (diff_w == '0);
    end
endmodule

// File: rtl/evt_wrap_det.sv
// Module: flags a wrap of the lower counter half.
// Assumes the counter only moves forward, so a smaller lower half than in the
// previous clock means the half passed its all-ones value.
module evt_wrap_det #(
    parameter int HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] count_lo_i,
    output logic          wrapped_o
);
    logic [HW-1:0] prev_q;

    // Remember the lower half from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= count_lo_i;
    end

    // A decrease of the lower half marks the wrap.
    assign wrapped_o = (count_lo_i < prev_q);
endmodule

// File: rtl/evt_wr_merge.sv
// Module: merges a half-width comparator write into the comparator and hidden period.
// Set-value gates the comparator in periodic mode. Narrow periodic writes
// clamp the period half to the largest positive half-width value.
module evt_wr_merge
    import evt_pkg::*;
#(
    parameter int W = 64
) (
    input  chan_cfg_t          cfg_i,
    input  logic [W-1:0]       cmp_i,
    input  logic [W-1:0]       per_i,
    input  logic               lo_we_i,
    input  logic               hi_we_i,
    input  logic [W/2-1:0]     wdata_i,
    output logic [W-1:0]       cmp_o,
    output logic [W-1:0]       per_o
);
    localparam int HW = W / 2;
    localparam logic [HW-1:0] PER_MAX = {1'b0, {(HW-1){1'b1}}};

    logic [HW-1:0] per_wd;
    logic          load_cmp;

    // Clamp the period value and decide whether the comparator is loaded.
    always_comb begin
        per_wd   = (cfg_i.narrow && (wdata_i > PER_MAX)) ? PER_MAX : wdata_i;
        load_cmp = !cfg_i.periodic || cfg_i.setv;
    end

    // Place the written half into the comparator and the period.
    always_comb begin
        cmp_o = cmp_i;
        per_o = per_i;
        if (lo_we_i) begin
            if (load_cmp)       cmp_o[HW-1:0] = wdata_i;
            if (cfg_i.periodic) per_o[HW-1:0] = per_wd;
        end
        if (hi_we_i) begin
            if (load_cmp)       cmp_o[W-1:HW] = wdata_i;
            if (cfg_i.periodic) per_o[W-1:HW] = per_wd;
        end
    end
endmodule

// File: rtl/evt_cmp_channel.sv
// Module: one comparator channel of an event timer.
// Watches a shared counter and pulses fire_o one clock after the comparator is
// reached. Supports one-shot, periodic with catch-up, narrow mode with wrap
// firing, and a self-clearing set-value bit. Assumes the period exceeds the
// counter advance per clock, so that catch-up terminates.
module evt_cmp_channel
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 glb_en_i,
    input  logic                 cfg_we_i,
    input  logic [CFG_WR_W-1:0]  cfg_wdata_i,
    input  logic                 cmp_lo_we_i,
    input  logic                 cmp_hi_we_i,
    input  logic [CNT_W/2-1:0]   cmp_wdata_i,
    output logic [CNT_W-1:0]     cmp_o,
    output logic [CFG_W-1:0]     cfg_o,
    output logic                 fire_o
);
    localparam int HALF_W = CNT_W / 2;

    chan_cfg_t          cfg_q, cfg_new, cfg_nx, cfg_eff;
    logic [CNT_W-1:0]   cmp_q, per_q;
    logic [CNT_W-1:0]   cmp_m, per_m, cmp_x, per_x, adv, sum;
    logic               armed_q, catch_q, wrap_pend_q, glb_q, fire_q;
    logic               reached, wrapped, wrap_hit, hit, per_active;
    logic               cmp_wr, en_rise, en_fall, glb_rise, arm_req, disarm, wrap_pend_n;

    // Reached test on the live comparator.
    evt_reach #(.W(CNT_W)) u_reach (
        .cmp_i     (cmp_q),
        .count_i   (count_i),
        .narrow_i  (cfg_q.narrow),
        .reached_o (reached)
    );

    // Lower-half wrap detection.
    evt_wrap_det #(.HW(HALF_W)) u_wrap (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_lo_i (count_i[HALF_W-1:0]),
        .wrapped_o  (wrapped)
    );

    // Comparator and period write merge.
    evt_wr_merge #(.W(CNT_W)) u_merge (
        .cfg_i   (cfg_q),
        .cmp_i   (cmp_q),
        .per_i   (per_q),
        .lo_we_i (cmp_lo_we_i),
        .hi_we_i (cmp_hi_we_i),
        .wdata_i (cmp_wdata_i),
        .cmp_o   (cmp_m),
        .per_o   (per_m)
    );

    // Configuration write decode and next configuration.
    always_comb begin
        cfg_new = chan_cfg_t'(cfg_wdata_i);
        cmp_wr  = cmp_lo_we_i || cmp_hi_we_i;
        cfg_nx  = cfg_q;
        if (cfg_we_i)    cfg_nx = cfg_new;
        else if (cmp_wr) cfg_nx.setv = 1'b0;
        cfg_eff = cfg_we_i ? cfg_new : cfg_q;
    end

    // Narrow selection truncates comparator and period in the writing clock.
    always_comb begin
        cmp_x = cmp_m;
        per_x = per_m;
        if (cfg_we_i && cfg_new.narrow) begin
            cmp_x[CNT_W-1:HALF_W] = '0;
            per_x[CNT_W-1:HALF_W] = '0;
        end
    end

    // Periodic advance, limited to the lower half in narrow mode.
    always_comb begin
        sum = cmp_q + per_q;
        adv = sum;
        if (cfg_q.narrow) adv[CNT_W-1:HALF_W] = '0;
        per_active = cfg_q.periodic && (per_q != '0);
    end

    // Match and wrap events that produce a pulse.
    always_comb begin
        wrap_hit = wrap_pend_q && wrapped;
        hit      = armed_q && glb_en_i && !catch_q && (reached || wrap_hit);
    end

    // Arm and disarm conditions.
    always_comb begin
        en_rise     = cfg_we_i && cfg_new.en && !cfg_q.en;
        en_fall     = cfg_we_i && !cfg_new.en && cfg_q.en;
        glb_rise    = glb_en_i && !glb_q;
        arm_req     = glb_en_i && cfg_eff.en && (en_rise || glb_rise || cmp_wr);
        disarm      = en_fall || !glb_en_i;
        wrap_pend_n = cfg_eff.narrow && !cfg_eff.periodic &&
                      (cmp_x[HALF_W-1:0] < count_i[HALF_W-1:0]);
    end

    // Channel state: writes first, then match handling, then catch-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cmp_q       <= '1;
            per_q       <= '0;
            armed_q     <= 1'b0;
            catch_q     <= 1'b0;
            wrap_pend_q <= 1'b0;
            glb_q       <= 1'b0;
            fire_q      <= 1'b0;
        end else begin
            glb_q  <= glb_en_i;
            fire_q <= hit;
            cfg_q  <= cfg_nx;
            if (cfg_we_i || cmp_wr) begin
                cmp_q   <= cmp_x;
                per_q   <= per_x;
                catch_q <= 1'b0;
            end else if (hit) begin
                if (per_active) begin
                    cmp_q   <= adv;
                    catch_q <= 1'b1;
                end else if (wrap_hit && !reached) begin
                    wrap_pend_q <= 1'b0;
                end else begin
                    armed_q <= 1'b0;
                end
            end else if (catch_q) begin
                if (reached) cmp_q   <= adv;
                else         catch_q <= 1'b0;
            end
            if (disarm) begin
                armed_q     <= 1'b0;
                catch_q     <= 1'b0;
                wrap_pend_q <= 1'b0;
            end else if (arm_req) begin
                armed_q     <= 1'b1;
                catch_q     <= 1'b0;
                wrap_pend_q <= wrap_pend_n;
            end
        end
    end

    assign cmp_o  = cmp_q;
    assign cfg_o  = {2'b11, cfg_q};
    assign fire_o = fire_q;
endmodule

// File: rtl/evt_chan_chk.sv
// Checker: port-level properties of the comparator channel, bound to the top.
module evt_chan_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en_i,
    input logic             cfg_we_i,
    input logic             nar_wr_i,
    input logic             cmp_lo_we_i,
    input logic             cmp_hi_we_i,
    input logic [CNT_W-1:0] cmp_o,
    input logic [3:0]       cfg_o,
    input logic             fire_o
);
    localparam int HALF_W = CNT_W / 2;

    logic was_rst;

    // Track whether the previous clock was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: state right after reset.
    always @(posedge clk) begin
        if (was_rst && rst_n) begin
            a_r1_reset_state: assert (cmp_o == '1 && cfg_o == 4'h0 && !fire_o)
                else $error("reset state wrong");
        end
    end

    // R7: set-value clears after a comparator write.
    a_r7_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i |=> !cfg_o[3]);

    // R4: disabled channel or timer produces no pulse.
    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_o[0] || !glb_en_i) |=> !fire_o);

    // R9: selecting narrow clears the upper comparator half.
    a_r9_narrow_truncates: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && nar_wr_i |=> cmp_o[CNT_W-1:HALF_W] == '0);

    // R9: in narrow mode the upper half stays clear without an upper write.
    a_r9_narrow_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[2] && !cfg_we_i && !cmp_hi_we_i && (cmp_o[CNT_W-1:HALF_W] == '0)
        |=> cmp_o[CNT_W-1:HALF_W] == '0);

    // R6: periodic write without set-value leaves the comparator alone.
    a_r6_period_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i && cfg_o[1] && !cfg_o[3]
        |=> $stable(cmp_o));
endmodule

bind evt_cmp_channel evt_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en_i    (glb_en_i),
    .cfg_we_i    (cfg_we_i),
    .nar_wr_i    (cfg_wdata_i[2]),
    .cmp_lo_we_i (cmp_lo_we_i),
    .cmp_hi_we_i (cmp_hi_we_i),
    .cmp_o       (cmp_o),
    .cfg_o       (cfg_o[3:0]),
    .fire_o      (fire_o)
);

// File: tb/test_evt_cmp_channel.sv
module test_evt_cmp_channel;
    localparam int CNT_W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        glb_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic        lo_we = 1'b0;
    logic        hi_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [63:0] cmp_o;
    logic [5:0]  cfg_o;
    logic        fire_o;

    int nvec = 0;
    int nbad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    evt_cmp_channel #(.CNT_W(CNT_W)) i_evt_cmp_channel (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb_en),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we), .cmp_wdata_i(wdata),
        .cmp_o(cmp_o), .cfg_o(cfg_o), .fire_o(fire_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic step(input logic [63:0] c);
        cnt = c;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic wr_cfg(input logic en, input logic per, input logic nar, input logic sv);
        cfg_we = 1'b1;
        cfg_wdata = {sv, nar, per, en};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] d);
        lo_we = 1'b1; wdata = d;
        @(negedge clk);
        lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] d);
        hi_we = 1'b1; wdata = d;
        @(negedge clk);
        hi_we = 1'b0;
    endtask

    // Expected comparator after a one-half write (R6).
    function automatic logic [63:0] exp_merge(input logic [63:0] c, input logic per,
                                              input logic sv, input logic hi,
                                              input logic [31:0] d);
        logic [63:0] r;
        r = c;
        if (!per || sv) begin
            if (hi) r[63:32] = d;
            else    r[31:0]  = d;
        end
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [63:0] mcmp;
        void'($urandom(32'h5eed));
        @(negedge clk);
        do_reset();

        // R1: reset values
        chk("R1 cmp", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 cfg", {58'd0, cfg_o}, 64'h30);
        chk("R1 fire", {63'd0, fire_o}, 64'd0);

        // R6 / R7: random write semantics with the channel disabled
        glb_en = 1'b1;
        mcmp = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int i = 0; i < 40; i++) begin
            logic per, sv, hi;
            logic [31:0] d;
            per = 1'($urandom % 2);
            sv  = 1'($urandom % 2);
            hi  = 1'($urandom % 2);
            d   = $urandom;
            wr_cfg(1'b0, per, 1'b0, sv);
            if (hi) wr_hi(d); else wr_lo(d);
            mcmp = exp_merge(mcmp, per, sv, hi, d);
            chk("R6 cmp after write", cmp_o, mcmp);
            chk("R7 setval cleared", {63'd0, cfg_o[3]}, 64'd0);
        end

        // R2 / R5: random one-shot match timing at full width
        for (int i = 0; i < 20; i++) begin
            logic [63:0] base;
            int k;
            base = {$urandom, $urandom};
            k = 2 + int'($urandom % 12);
            wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
            wr_hi(32'((base + 64'(k)) >> 32));
            wr_lo(32'(base + 64'(k)));
            cnt = base;
            wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
            for (int j = 1; j <= k + 2; j++) begin
                step(base + 64'(j));
                chk((j > k) ? "R5 no refire" : "R2 fire timing",
                    {63'd0, fire_o}, {63'd0, (j == k)});
            end
        end

        // R3: comparator in the past fires at once
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        wr_hi(32'd0);
        wr_lo(32'd500);
        cnt = 64'd1000;
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R3 past fires", {63'd0, fire_o}, 64'd1);
        tick();
        chk("R5 single pulse", {63'd0, fire_o}, 64'd0);

        // R13: comparator write while enabled re-arms
        wr_lo(32'd1010);
        step(64'd1005);
        chk("R13 not yet", {63'd0, fire_o}, 64'd0);
        step(64'd1010);
        chk("R13 rearmed fire", {63'd0, fire_o}, 64'd1);
        step(64'd1011);
        chk("R13 pulse ends", {63'd0, fire_o}, 64'd0);

        // R4: global enable low blocks arming; its rising edge arms
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        glb_en = 1'b0;
        wr_lo(32'd100);
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 global off silent", {63'd0, fire_o}, 64'd0);
        end
        glb_en = 1'b1;
        tick();
        chk("R4 arming clock", {63'd0, fire_o}, 64'd0);
        tick();
        chk("R4 global rise arms", {63'd0, fire_o}, 64'd1);
        wr_lo(32'd2000);
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        step(64'd2000);
        chk("R4 disarmed", {63'd0, fire_o}, 64'd0);
        step(64'd2001);
        chk("R4 disarmed", {63'd0, fire_o}, 64'd0);

        // R8: periodic advance and catch-up
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        wr_hi(32'd0);
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        wr_lo(32'd100);
        chk("R6 setval loads cmp", cmp_o, 64'd100);
        cnt = 64'd50;
        wr_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step(64'd100);
        chk("R8 first fire", {63'd0, fire_o}, 64'd1);
        chk("R8 advanced", cmp_o, 64'd200);
        step(64'd150);
        chk("R8 no fire", {63'd0, fire_o}, 64'd0);
        step(64'd450);
        chk("R8 late fire", {63'd0, fire_o}, 64'd1);
        chk("R8 step1", cmp_o, 64'd300);
        step(64'd450);
        chk("R8 catchup silent", {63'd0, fire_o}, 64'd0);
        chk("R8 step2", cmp_o, 64'd400);
        step(64'd450);
        chk("R8 step3", cmp_o, 64'd500);
        step(64'd460);
        chk("R8 caught up", cmp_o, 64'd500);
        chk("R8 caught up silent", {63'd0, fire_o}, 64'd0);
        step(64'd500);
        chk("R8 next fire", {63'd0, fire_o}, 64'd1);
        chk("R8 next value", cmp_o, 64'd600);

        // R12: zero period behaves as one-shot
        do_reset();
        glb_en = 1'b1;
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        wr_hi(32'd0);
        wr_lo(32'd300);
        cnt = 64'd0;
        wr_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step(64'd300);
        chk("R12 fire", {63'd0, fire_o}, 64'd1);
        chk("R12 cmp still", cmp_o, 64'd300);
        step(64'd301);
        chk("R12 no refire", {63'd0, fire_o}, 64'd0);
        step(64'd600);
        chk("R12 silent", {63'd0, fire_o}, 64'd0);
        chk("R12 cmp held", cmp_o, 64'd300);

        // R9: narrow truncates; R10: clamp of narrow period
        do_reset();
        glb_en = 1'b1;
        wr_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 truncated", cmp_o, 64'h0000_0000_FFFF_FFFF);
        wr_cfg(1'b0, 1'b1, 1'b1, 1'b0);
        wr_lo(32'hFFFF_FFFF);
        chk("R6 period only", cmp_o, 64'h0000_0000_FFFF_FFFF);
        cnt = 64'hFFFF_FF00;
        wr_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        step(64'hFFFF_FFFF);
        chk("R10 fire", {63'd0, fire_o}, 64'd1);
        chk("R10 clamped advance", cmp_o, 64'h0000_0000_7FFF_FFFE);
        step(64'hFFFF_FFFF);
        chk("R10 single advance", cmp_o, 64'h0000_0000_7FFF_FFFE);

        // R9: only the lower half is compared
        wr_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        wr_lo(32'h200);
        cnt = 64'h5_0000_0100;
        wr_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R9 upper ignored", {63'd0, fire_o}, 64'd0);
        step(64'h5_0000_0200);
        chk("R9 low match", {63'd0, fire_o}, 64'd1);
        step(64'h5_0000_0201);
        chk("R9 pulse ends", {63'd0, fire_o}, 64'd0);

        // R11: narrow one-shot fires on wrap and at the match
        wr_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        wr_lo(32'h10);
        cnt = 64'hF000_0000;
        wr_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        step(64'hFFFF_FFFF);
        chk("R11 before wrap", {63'd0, fire_o}, 64'd0);
        step(64'h1_0000_0002);
        chk("R11 wrap fire", {63'd0, fire_o}, 64'd1);
        step(64'h1_0000_0003);
        chk("R11 between", {63'd0, fire_o}, 64'd0);
        step(64'h1_0000_0010);
        chk("R11 match fire", {63'd0, fire_o}, 64'd1);
        step(64'h1_0000_0011);
        chk("R11 done", {63'd0, fire_o}, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule